// File: doc/BRIEF.md
# Double-Buffered 8-Bit PWM Timer

This block produces a pulse-width modulated waveform with 8-bit resolution. An 8-bit up-counter advances on a tick from a small enable divider. The divider can pass every system clock, every second clock or every fourth clock. A toggle flop flips when the count equals the active compare value and flips again when the counter wraps from 255 to 0. The output pin carries the inverse of that flop, so each period starts high and falls after the compare point. At every wrap the block raises an interrupt pulse one clock wide.

Software writes the duty value into a holding stage. The holding stage moves into the active compare stage at two moments only: on the rising edge of the run control, or at a counter wrap. Because of this, the duty cycle can be rewritten at any time without cutting a period short or producing a glitch. Every part of the block runs on one clock, and the slower count rates come from enable pulses.

Top module: `pwm8_timer`

## Requirements
- R1: The 8-bit counter advances by one on each tick and returns from 255 to 0, so one output period lasts 256 ticks.
- R2: For an active compare value C, `pwm_out` is 1 while the count is 0 through C (C+1 ticks) and 0 for the rest of the period. When C equals 255, the compare toggle and the wrap toggle fall on the same tick and cancel, so the output stays 1 for the whole period.
- R3: `pwm_out` is the inverse of the internal toggle flop. While the timer is stopped, `pwm_out` is 1.
- R4: `clk_sel` sets the tick rate. A value of 0 gives a tick on every clock, 1 gives one tick every 2 clocks, and both 2 and 3 give one tick every 4 clocks.
- R5: A write made while the timer runs leaves the active compare value unchanged until the next wrap. The new duty applies from count 0 of the following period.
- R6: A value written while `run` is 0 becomes the active compare value on the clock where `run` is first seen as 1. Counting starts on the clock after that.
- R7: `ovf_irq` is high for exactly one clock, on the cycle after each wrap edge, once per period.
- R8: While `run` is 0, the counter is held at 0, the toggle flop is held cleared and `ovf_irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Duty (compare) value to be written |
| run | input | 1 | Start/run control; 0 stops and clears the timer |
| clk_sel | input | 2 | Tick rate: 0 = every clock, 1 = every 2nd clock, 2 or 3 = every 4th clock |
| pwm_out | output | 1 | PWM output, inverse of the toggle flop |
| ovf_irq | output | 1 | One-clock pulse after each counter wrap |

## Verification
The bench targets the compare extremes 0, 1, 128 and 255. A design that applies the two toggles at 255 wrongly would give a 0% or inverted period instead of a constant high, and an off-by-one compare would give C or C+2 high ticks instead of C+1. It writes a new duty in the middle of a period. A design without the holding stage would change the current period's pulse width, and one that loads late would keep the old duty for an extra period. Every tick rate is measured over a full period, so a divider that counts wrongly shows up as a wrong period length. Idle stretches check that a stopped timer holds the pin high and never raises the interrupt.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
    localparam int CNT_WIDTH = 8;
    localparam int PRE_WIDTH = 2;

    typedef enum logic [1:0] {
        SEL_DIV1  = 2'd0,
        SEL_DIV2  = 2'd1,
        SEL_DIV4  = 2'd2,
        SEL_DIV4B = 2'd3
    } clk_sel_e;
endpackage

// File: rtl/pwm8_prescale.sv
module pwm8_prescale
    import pwm8_pkg::*;
#(
    parameter int PRE_W = PRE_WIDTH
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       tick
);
    typedef struct packed {
        logic [PRE_W-1:0] div;
    } pre_state_t;

    pre_state_t s_q, s_d;
    logic [PRE_W-1:0] mask;

    always_comb begin
        case (clk_sel_e'(sel))
            SEL_DIV1: mask = '0;
            SEL_DIV2: mask = PRE_W'(1);
            default:  mask = PRE_W'(3);
        endcase
        tick = en && ((s_q.div & mask) == mask);
        s_d  = s_q;
        if (!en) s_d.div = '0;
        else     s_d.div = s_q.div + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: with a divided rate, two ticks never arrive on consecutive clocks
    a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != 2'd0) |=> (!tick || sel != $past(sel)));
endmodule

// File: rtl/pwm8_cmpbuf.sv
module pwm8_cmpbuf
    import pwm8_pkg::*;
#(
    parameter int W = CNT_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         start,
    input  logic         wrap,
    output logic [W-1:0] cmp_act
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] act;
    } buf_state_t;

    buf_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (wr_en)         s_d.hold = wr_data;
        if (start || wrap) s_d.act  = s_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmp_act = s_q.act;
endmodule

// File: rtl/pwm8_core.sv
module pwm8_core
    import pwm8_pkg::*;
#(
    parameter int W = CNT_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         tick,
    input  logic [W-1:0] cmp_act,
    output logic         ff,
    output logic         irq,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ff;
        logic         irq;
    } core_state_t;

    core_state_t s_q, s_d;
    logic match, at_top;

    always_comb begin
        match  = (s_q.cnt == cmp_act);
        at_top = (s_q.cnt == TOP);
        wrap   = active && tick && at_top;
        s_d    = s_q;
        if (!active) begin
            s_d = '0;
        end else begin
            s_d.irq = wrap;
            if (tick) begin
                // compare toggle first, wrap toggle second; equal ticks cancel
                s_d.ff  = (s_q.ff ^ match) ^ at_top;
                s_d.cnt = at_top ? '0 : s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ff  = s_q.ff;
    assign irq = s_q.irq;

    // R7: interrupt lasts a single clock
    a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |=> !s_q.irq);
    // R1: the interrupt follows the wrap, so the counter is back at zero
    a_r1_irq_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |-> (s_q.cnt == '0));
    // R8: a stopped timer clears counter, flop and interrupt
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (s_q.cnt == '0 && !s_q.ff && !s_q.irq));
    // R5: the active compare value changes only at a period boundary
    a_r5_cmp_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_act) |-> (s_q.cnt == '0));
    // R2: every period begins with the flop cleared (output high)
    a_r2_clear_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == '0) |-> !s_q.ff);
endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
    import pwm8_pkg::*;
#(
    parameter int W     = CNT_WIDTH,
    parameter int PRE_W = PRE_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         run,
    input  logic [1:0]   clk_sel,
    output logic         pwm_out,
    output logic         ovf_irq
);
    typedef struct packed {
        logic run;
    } top_state_t;

    top_state_t s_q, s_d;
    logic start, active, tick, wrap, ff;
    logic [W-1:0] cmp_act;

    always_comb begin
        s_d.run = run;
        start   = run && !s_q.run;
        active  = run && s_q.run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    pwm8_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (active),
        .sel  (clk_sel),
        .tick (tick)
    );

    pwm8_cmpbuf #(.W(W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .start  (start),
        .wrap   (wrap),
        .cmp_act(cmp_act)
    );

    pwm8_core #(.W(W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .tick   (tick),
        .cmp_act(cmp_act),
        .ff     (ff),
        .irq    (ovf_irq),
        .wrap   (wrap)
    );

    assign pwm_out = ~ff;

    // R3: a stopped timer drives the pin high
    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> pwm_out);
endmodule

// File: tb/sim_pwm8_timer.sv
module sim_pwm8_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       run = 1'b0;
    logic [1:0] clk_sel = '0;
    logic       pwm_out, ovf_irq;
    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    pwm8_timer u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .run    (run),
        .clk_sel(clk_sel),
        .pwm_out(pwm_out),
        .ovf_irq(ovf_irq)
    );

    // {compare, clk_sel, expected high clocks, expected period clocks}
    localparam int NVEC = 7;
    localparam logic [41:0] VEC [NVEC] = '{
        {8'd0,   2'd0, 16'd1,   16'd256},
        {8'd1,   2'd0, 16'd2,   16'd256},
        {8'd128, 2'd0, 16'd129, 16'd256},
        {8'd255, 2'd0, 16'd256, 16'd256},
        {8'd64,  2'd1, 16'd130, 16'd512},
        {8'd200, 2'd2, 16'd804, 16'd1024},
        {8'd10,  2'd3, 16'd44,  16'd1024}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_irq(output bit ok);
        ok = 1'b0;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (ovf_irq) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    // starts on a sample where ovf_irq is 1, ends on the next such sample
    task automatic measure(input int wr_at, input logic [7:0] wv,
                           output int hi, output int per);
        hi = 0;
        per = 0;
        do begin
            if (pwm_out) hi++;
            per++;
            if (per == wr_at) begin
                wr_en = 1'b1;
                wr_data = wv;
            end
            if (per == wr_at + 1) wr_en = 1'b0;
            @(negedge clk);
        end while (!ovf_irq && per < 5000);
    endtask

    task automatic load_and_start(input logic [7:0] v, input logic [1:0] s);
        run = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        clk_sel = s;
        @(negedge clk);
        wr_en = 1'b0;
        run = 1'b1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        bit ok;
        int hi, per, irqs, lows;

        repeat (3) @(negedge clk);
        check("R3 reset pwm_out", int'(pwm_out), 1);
        check("R8 reset ovf_irq", int'(ovf_irq), 0);
        rst_n = 1'b1;

        // table of compare values and tick rates (R1 R2 R4 R6 R7)
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0]  vc = VEC[i][41:34];
            logic [1:0]  vs = VEC[i][33:32];
            logic [15:0] eh = VEC[i][31:16];
            logic [15:0] ep = VEC[i][15:0];
            load_and_start(vc, vs);
            wait_irq(ok);
            check("R6 first wrap seen", int'(ok), 1);
            measure(0, 8'd0, hi, per);
            check("R2 R6 high clocks", hi, int'(eh));
            check("R1 R4 period clocks", per, int'(ep));
            @(negedge clk);
            check("R7 single-cycle irq", int'(ovf_irq), 0);
        end

        // R5: mid-period write keeps the old duty for the current period
        load_and_start(8'd50, 2'd0);
        wait_irq(ok);
        measure(5, 8'd100, hi, per);
        check("R5 current period keeps old duty", hi, 51);
        measure(0, 8'd0, hi, per);
        check("R5 next period takes new duty", hi, 101);

        // R3 R8: stopped timer stays high and silent
        run = 1'b0;
        @(negedge clk);
        irqs = 0;
        lows = 0;
        for (int n = 0; n < 300; n++) begin
            if (ovf_irq) irqs++;
            if (!pwm_out) lows++;
            @(negedge clk);
        end
        check("R8 no irq while stopped", irqs, 0);
        check("R3 pin high while stopped", lows, 0);

        summary();
        $finish;
    end
endmodule